// File: doc/BRIEF.md
# Slave-Timed 4:2:2 Pixel Input Aligner

This block accepts an 8-bit byte stream that carries 4:2:2 component video with the chroma and luma samples multiplexed on one bus. Alongside it come externally generated horizontal and vertical sync inputs, and everything shares one 27 MHz clock. The block runs in slave timing, which is its only mode and the mode it is in after reset. A clock counter restarts on each rising edge of the horizontal sync. The count selects the active window for the chosen line standard, and the position of a byte within that window gives its component.

Each recovered pixel comes out as one Y value with the Cb and Cr of its pair and a pixel index from 0 to 719, marked by a one-cycle valid strobe. A sync-delay input moves the whole window one clock later. The block also gives a one-cycle line-start pulse, a line number that is cleared by the vertical sync, and a line-error flag for lines that run past their nominal length.

Top module: `vid_in_align`

## Requirements
- R1: While rst_ni is low, pix_valid_o, line_start_o and line_err_o are 0 and line_num_o is 0.
- R2: The byte sampled on the clock edge that sees hsync_i rise has count 1, and each later byte adds one to the count. line_start_o is high for exactly one cycle, and that cycle follows the second clock edge of the line.
- R3: With std_sel_i = 0 (1716-count line), the active window starts at count 245 when sync_dly_i = 0 and at count 246 when sync_dly_i = 1. The window spans 1440 bytes, so with no delay the last byte is count 1684.
- R4: With std_sel_i = 1 (1728-count line), the active window starts at count 265 when sync_dly_i = 0 and at count 266 when sync_dly_i = 1, and spans 1440 bytes.
- R5: Inside the window the bytes repeat the order Cb, Y, Cr, Y, starting at offset 0. Pixel 2k takes the first Y of pair k and pixel 2k+1 takes the second Y. Both pixels carry the Cb and Cr of pair k. pix_valid_o pulses once per Y byte, 720 times on a full line, and pix_idx_o runs from 0 to 719. A pixel appears one clock after the later of its Y byte and its Cr byte is counted.
- R6: When a line passes its nominal count without a new hsync_i edge, the counter holds at the nominal count, line_err_o rises and no further pixels appear. The next hsync_i edge clears line_err_o.
- R7: An hsync_i edge that arrives inside the window restarts the count at once. Pixels whose bytes are not yet complete are dropped, and the pixels already finished keep their order.
- R8: A rising edge of vsync_i clears line_num_o to 0, and each rising edge of hsync_i adds one to it. Both take effect on the edge that samples them.
- R9: Before the first hsync_i edge after reset, no pixel is produced, whatever data_i carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std_sel_i | input | 1 | Line standard: 0 = 1716 counts, 1 = 1728 counts |
| sync_dly_i | input | 1 | 1 starts the window one clock later |
| hsync_i | input | 1 | External horizontal sync, rising edge starts a line |
| vsync_i | input | 1 | External vertical sync, rising edge clears the line number |
| data_i | input | 8 | Multiplexed Cb/Y/Cr/Y byte stream |
| pix_valid_o | output | 1 | One-cycle strobe per recovered pixel |
| y_o | output | 8 | Luma of the pixel |
| cb_o | output | 8 | Blue-difference chroma of the pixel pair |
| cr_o | output | 8 | Red-difference chroma of the pixel pair |
| pix_idx_o | output | 10 | Pixel index within the line |
| line_start_o | output | 1 | One-cycle pulse at the start of each line |
| line_err_o | output | 1 | Line overran its nominal count |
| line_num_o | output | 10 | Lines since the last vertical sync |

## Verification
Every byte value depends on its count and on the line, so a window that is off by one clock in either direction shows up as shifted components on each pixel. The one-clock delay is tested under both standards because of this. A mix-up between the two luma bytes of a pair, or a pixel built before its Cr has arrived, gives wrong Y or Cr values against the scoreboard. Lines three counts too long must hold the count and raise the error flag without adding pixels. A line cut short by an early sync must drop only the unfinished pixels. A design that freezes the count, fails to clear it, or ignores the vertical sync reports the wrong line number or the wrong number of line-start pulses.

// File: rtl/vid_in_pkg.sv
package vid_in_pkg;
  typedef enum logic {
    VID_STD_525 = 1'b0,
    VID_STD_625 = 1'b1
  } vid_std_e;

  // byte position inside a two-pixel group; order is behaviour
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } byte_ph_e;
endpackage

// File: rtl/vid_edge_det.sv
module vid_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/vid_line_cnt.sv
module vid_line_cnt #(
  parameter int CNT_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_rise_i,
  input  logic              vs_rise_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              err_o,
  output logic [LINE_W-1:0] line_num_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      err_o <= 1'b0;
    end else if (hs_rise_i) begin
      cnt_o <= CNT_W'(1);
      err_o <= 1'b0;
    end else if (cnt_o != '0) begin
      if (cnt_o >= len_i) err_o <= 1'b1;  // hold at nominal length
      else                cnt_o <= cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               line_num_o <= '0;
    else if (vs_rise_i)                        line_num_o <= '0;
    else if (hs_rise_i && line_num_o != LINE_MAX) line_num_o <= line_num_o + 1'b1;
  end
endmodule

// File: rtl/vid_win_dec.sv
module vid_win_dec #(
  parameter int CNT_W     = 11,
  parameter int IDX_W     = 10,
  parameter int WIN_BYTES = 1440
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] start_i,
  output logic             in_win_o,
  output logic [1:0]       phase_o,
  output logic [IDX_W-2:0] pair_o
);
  logic [CNT_W-1:0] off;

  assign off      = cnt_i - start_i;
  assign in_win_o = (cnt_i >= start_i) && (32'(off) < WIN_BYTES);
  assign phase_o  = off[1:0];
  assign pair_o   = (IDX_W-1)'(off >> 2);
endmodule

// File: rtl/vid_byte_demux.sv
module vid_byte_demux
  import vid_in_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              first_i,
  input  logic              in_win_i,
  input  logic [1:0]        phase_i,
  input  logic [IDX_W-2:0]  pair_i,
  output logic [DATA_W-1:0] data_q_o,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] cr_o,
  output logic [IDX_W-1:0]  pix_idx_o,
  output logic              line_start_o
);
  logic [DATA_W-1:0] cb_hold, cr_hold, y0_hold;
  byte_ph_e ph;

  assign ph = byte_ph_e'(phase_i);

  // byte register aligned with the count register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q_o <= '0;
    else         data_q_o <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cb_hold      <= '0;
      cr_hold      <= '0;
      y0_hold      <= '0;
      pix_valid_o  <= 1'b0;
      y_o          <= '0;
      cb_o         <= '0;
      cr_o         <= '0;
      pix_idx_o    <= '0;
      line_start_o <= 1'b0;
    end else begin
      pix_valid_o  <= 1'b0;
      line_start_o <= first_i;
      if (in_win_i) begin
        case (ph)
          PH_CB: cb_hold <= data_q_o;
          PH_Y0: y0_hold <= data_q_o;
          PH_CR: begin
            // even pixel waits for its pair's Cr
            cr_hold     <= data_q_o;
            pix_valid_o <= 1'b1;
            y_o         <= y0_hold;
            cb_o        <= cb_hold;
            cr_o        <= data_q_o;
            pix_idx_o   <= {pair_i, 1'b0};
          end
          PH_Y1: begin
            pix_valid_o <= 1'b1;
            y_o         <= data_q_o;
            cb_o        <= cb_hold;
            cr_o        <= cr_hold;
            pix_idx_o   <= {pair_i, 1'b1};
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vid_in_align.sv
module vid_in_align
  import vid_in_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LEN_525   = 1716,
  parameter int LEN_625   = 1728,
  parameter int START_525 = 245,
  parameter int START_625 = 265,
  parameter int ACT_PIX   = 720,
  parameter int LINE_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              std_sel_i,
  input  logic              sync_dly_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] cr_o,
  output logic [$clog2(ACT_PIX)-1:0] pix_idx_o,
  output logic              line_start_o,
  output logic              line_err_o,
  output logic [LINE_W-1:0] line_num_o
);
  localparam int LEN_MAX   = (LEN_525 > LEN_625) ? LEN_525 : LEN_625;
  localparam int CNT_W     = $clog2(LEN_MAX + 1);
  localparam int IDX_W     = $clog2(ACT_PIX);
  localparam int WIN_BYTES = 2 * ACT_PIX;
  localparam int N_SYNC    = 2;

  vid_std_e         std;
  logic [CNT_W-1:0] line_len, win_start, cnt_q;
  logic [N_SYNC-1:0] sync_in, sync_rise;
  logic             hs_rise, vs_rise;
  logic             in_win;
  logic [1:0]       phase;
  logic [IDX_W-2:0] pair;
  logic [DATA_W-1:0] data_q;

  assign std       = vid_std_e'(std_sel_i);
  assign line_len  = (std == VID_STD_625) ? CNT_W'(LEN_625) : CNT_W'(LEN_525);
  assign win_start = ((std == VID_STD_625) ? CNT_W'(START_625) : CNT_W'(START_525))
                     + CNT_W'(sync_dly_i);

  assign sync_in = {vsync_i, hsync_i};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    vid_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (sync_in[g]),
      .rise_o (sync_rise[g])
    );
  end

  assign hs_rise = sync_rise[0];
  assign vs_rise = sync_rise[1];

  vid_line_cnt #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hs_rise_i  (hs_rise),
    .vs_rise_i  (vs_rise),
    .len_i      (line_len),
    .cnt_o      (cnt_q),
    .err_o      (line_err_o),
    .line_num_o (line_num_o)
  );

  vid_win_dec #(.CNT_W(CNT_W), .IDX_W(IDX_W), .WIN_BYTES(WIN_BYTES)) u_win (
    .cnt_i    (cnt_q),
    .start_i  (win_start),
    .in_win_o (in_win),
    .phase_o  (phase),
    .pair_o   (pair)
  );

  vid_byte_demux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_demux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .data_i       (data_i),
    .first_i      (cnt_q == CNT_W'(1)),
    .in_win_i     (in_win),
    .phase_i      (phase),
    .pair_i       (pair),
    .data_q_o     (data_q),
    .pix_valid_o  (pix_valid_o),
    .y_o          (y_o),
    .cb_o         (cb_o),
    .cr_o         (cr_o),
    .pix_idx_o    (pix_idx_o),
    .line_start_o (line_start_o)
  );
endmodule

// File: rtl/vid_in_align_chk.sv
module vid_in_align_chk #(
  parameter int CNT_W   = 11,
  parameter int IDX_W   = 10,
  parameter int LINE_W  = 10,
  parameter int ACT_PIX = 720
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hs_rise,
  input logic              vs_rise,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  line_len,
  input logic              pix_valid_o,
  input logic [IDX_W-1:0]  pix_idx_o,
  input logic              line_start_o,
  input logic              line_err_o,
  input logic [LINE_W-1:0] line_num_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!pix_valid_o && !line_err_o && !line_start_o);
    end
  end

  assert_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_rise |=> cnt_q == CNT_W'(1));

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !hs_rise && cnt_q < line_len) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !line_start_o);

  assert_idx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> 32'(pix_idx_o) < ACT_PIX);

  assert_saturate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == line_len && !hs_rise) |=> (cnt_q == $past(cnt_q) && line_err_o));

  assert_err_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_rise |=> !line_err_o);

  assert_vsync_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise |=> line_num_o == '0);
endmodule

bind vid_in_align vid_in_align_chk #(
  .CNT_W(CNT_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .ACT_PIX(ACT_PIX)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hs_rise      (hs_rise),
  .vs_rise      (vs_rise),
  .cnt_q        (cnt_q),
  .line_len     (line_len),
  .pix_valid_o  (pix_valid_o),
  .pix_idx_o    (pix_idx_o),
  .line_start_o (line_start_o),
  .line_err_o   (line_err_o),
  .line_num_o   (line_num_o)
);

// File: tb/vid_in_align_tb.sv
module vid_in_align_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       std_sel_i = 1'b0;
  logic       sync_dly_i = 1'b0;
  logic       hsync_i = 1'b0;
  logic       vsync_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       pix_valid_o;
  logic [7:0] y_o, cb_o, cr_o;
  logic [9:0] pix_idx_o;
  logic       line_start_o, line_err_o;
  logic [9:0] line_num_o;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  int exp_line = 0;
  bit done = 1'b0;

  // expected pixel: {idx, y, cb, cr}
  logic [33:0] exp_q[$];
  string       tag_q[$];

  always #4ns clk_i = ~clk_i;

  vid_in_align u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .std_sel_i(std_sel_i), .sync_dly_i(sync_dly_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .data_i(data_i),
    .pix_valid_o(pix_valid_o), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o),
    .pix_idx_o(pix_idx_o), .line_start_o(line_start_o), .line_err_o(line_err_o),
    .line_num_o(line_num_o)
  );

  function automatic logic [7:0] byte_at(int c, int salt);
    return 8'((c * 37 + salt * 101 + 13) % 256);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected pixels as the design produces them
  always @(negedge clk_i) begin
    if (rst_ni && pix_valid_o) begin
      vcount++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected pixel actual idx %0d expected none", pix_idx_o);
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({pix_idx_o, y_o, cb_o, cr_o} !== e) begin
          fails++;
          $display("FAIL %s pixel actual idx %0d y %0d cb %0d cr %0d expected idx %0d y %0d cb %0d cr %0d",
                   t, pix_idx_o, y_o, cb_o, cr_o, e[33:24], e[23:16], e[15:8], e[7:0]);
        end
      end
    end
  end

  task automatic run_line(input logic std, input logic dly, input int len,
                          input int salt, input int vs_at, input string tag);
    int nom, st, ls_bad, ln_seen;
    bit err_seen;
    nom = std ? 1728 : 1716;
    st  = (std ? 265 : 245) + int'(dly);
    ls_bad = 0;
    ln_seen = -1;
    err_seen = 1'b0;
    for (int p = 0; p < 720; p++) begin
      int k, trig;
      logic [7:0] ey;
      k = p / 2;
      trig = st + 4 * k + 2 + (p % 2);
      ey = byte_at(st + 4 * k + 1 + 2 * (p % 2), salt);
      if (trig <= len) begin
        exp_q.push_back({10'(p), ey, byte_at(st + 4 * k, salt), byte_at(st + 4 * k + 2, salt)});
        tag_q.push_back(tag);
      end
    end
    exp_line++;
    for (int c = 1; c <= len; c++) begin
      @(negedge clk_i);
      if (line_start_o !== (c == 3)) ls_bad++;
      if (c == 3) ln_seen = int'(line_num_o);
      if (c >= 3 && line_err_o) err_seen = 1'b1;
      if (c == 2) begin
        std_sel_i  = std;
        sync_dly_i = dly;
      end
      hsync_i = (c <= 128);
      vsync_i = (c >= vs_at && c < vs_at + 4);
      data_i  = byte_at(c, salt);
    end
    check(ls_bad == 0, "R2", "line_start misplaced cycles", ls_bad, 0);
    check(ln_seen == exp_line, "R8", "line number", ln_seen, exp_line);
    check(err_seen == (len > nom), "R6", "line error flag", int'(err_seen), int'(len > nom));
    if (vs_at <= len) exp_line = 0;
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      data_i = 8'(i * 7 + 1);
    end
    check(!pix_valid_o && !line_start_o && !line_err_o && line_num_o == 0,
          "R1", "outputs in reset", int'(pix_valid_o) + int'(line_err_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // idle with live data and a vertical sync, no horizontal edge (R9)
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      data_i  = 8'(i * 13 + 3);
      vsync_i = (i >= 20 && i < 24);
    end
    check(vcount == 0, "R9", "pixels before first sync", vcount, 0);
    check(line_num_o == 0, "R8", "line number after vsync", int'(line_num_o), 0);

    run_line(1'b0, 1'b0, 1716, 1, 99999, "R3");
    run_line(1'b0, 1'b1, 1716, 2, 99999, "R3");
    run_line(1'b1, 1'b0, 1728, 3, 99999, "R4");
    run_line(1'b1, 1'b1, 1728, 4, 99999, "R4");
    run_line(1'b0, 1'b0, 1719, 5, 99999, "R6");
    run_line(1'b0, 1'b0, 1000, 6, 99999, "R7");
    run_line(1'b1, 1'b0, 1731, 7, 300, "R6");
    run_line(1'b0, 1'b1, 1716, 8, 99999, "R3");

    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      hsync_i = 1'b0;
    end
    check(exp_q.size() == 0, "R5", "missing pixels", exp_q.size(), 0);
    check(vcount == 7 * 720 + 378, "R7", "total pixels", vcount, 7 * 720 + 378);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule